// File: doc/BRIEF.md
# Configuration Byte Loader with Complement Check

This block fills two configuration registers from a small non-volatile configuration store. It runs on its own after a power-on reset, and runs again whenever software writes a one-cycle launch request. In each run it reads four 32-bit words through a synchronous read port with one cycle of latency. Each word carries two value bytes, and each value byte sits beside its bitwise complement.

Every value byte is checked against its partner. A byte that fails the check is replaced by 0xFF and sets a sticky error flag. A pair that is fully erased (both bytes 0xFF) gives 0xFF without an error. The checked bytes are gathered over the whole run. The option status register and the write-protection register are updated together in one cycle at the end of the run, and a one-cycle done pulse marks that update. An ordinary system reset only masks the software requests. It never starts a reload and never disturbs the registers.

Top module: `optload_top`

## Requirements
- R1: When power-on reset is released, a load starts by itself. Busy goes high, and the block issues reads on four consecutive cycles at byte addresses 0x00, 0x04, 0x08 and 0x0C (offset by the base address). Busy stays high for five cycles. While power-on reset is held, busy, done and both registers are zero.
- R2: A launch pulse while idle, with the system reset released, starts a load. A launch pulse during a load is ignored. Holding the system reset low, with launch high or with the system reset pulsed, starts nothing.
- R3: Each word is split as bits [31:24] = complement of the high byte, [23:16] = high byte, [15:8] = complement of the low byte, [7:0] = low byte. A byte that is the exact bitwise inverse of its complement is used unchanged.
- R4: A byte that is not the inverse of its complement, and is not an erased pair, is taken as 0xFF and sets the error flag.
- R5: A pair in which both bytes are 0xFF gives 0xFF and does not set the error flag.
- R6: The option status register holds the high byte of word 1 in [31:24], the low byte of word 1 in [23:16], the high byte of word 0 in [15:8], zeros in [7:3], the read-protection level in [2:1] and the error flag in [0].
- R7: The write-protection register holds, from bit 31 down, word 3 high, word 3 low, word 2 high and word 2 low. A cleared bit means that sector is protected.
- R8: The read-protection level comes from the low byte of word 0 after checking. 0xAA gives level 0, 0xCC gives level 2, and any other value gives level 1.
- R9: Apart from the error flag, both registers keep their old contents during a load. They are updated together on the last busy cycle. Done is high for exactly one cycle, the cycle right after the last busy cycle.
- R10: The error flag clears when a load starts, and also clears when software writes the clear input while the system reset is released. If a clear write falls in the same cycle as a commit that found an error, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, active low; masks launch and clear requests |
| launch_i | input | 1 | Software launch request, one cycle |
| err_clr_i | input | 1 | Software write that clears the error flag |
| mem_rd_o | output | 1 | Read strobe to the configuration store |
| mem_addr_o | output | ADDR_W | Byte address of the word being read |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the strobe |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse after the registers are updated |
| obr_o | output | 32 | Option status register |
| wrpr_o | output | 32 | Write-protection register |

## Verification
Two events can fall on the same edge: a software clear of the error flag, and the end-of-load commit that sets the flag again because a pair was corrupt. The bench provokes this by tracking the phase of its own model. It raises the clear input exactly in the last busy cycle of a load whose word 0 carries a bad pair. It then expects the flag to read set after done, because setting takes priority. A second collision, a launch request arriving in the middle of a load, is judged by the busy window keeping its five-cycle length.

// File: rtl/optload_pkg.sv
package optload_pkg;

  localparam int NUM_WORDS = 4;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int PAIRS     = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  bad;
    byte_t val;
  } pair_res_t;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_PART = 2'd1,
    LVL_FULL = 2'd2
  } rdp_lvl_t;

  localparam byte_t ERASED_B   = 8'hFF;
  localparam byte_t RDP_OPEN_B = 8'hAA;
  localparam byte_t RDP_FULL_B = 8'hCC;

  // Checks one value byte against its stored complement.
  function automatic pair_res_t pair_eval(byte_t v, byte_t c);
    pair_res_t r;
    if ((v ^ c) == '1) begin
      r.bad = 1'b0;
      r.val = v;
    end else begin
      r.val = ERASED_B;
      r.bad = !((v == ERASED_B) && (c == ERASED_B));
    end
    return r;
  endfunction

  // Maps the checked protection byte onto a 2-bit level.
  function automatic rdp_lvl_t rdp_level(byte_t v);
    rdp_lvl_t l;
    if (v == RDP_OPEN_B)      l = LVL_OPEN;
    else if (v == RDP_FULL_B) l = LVL_FULL;
    else                      l = LVL_PART;
    return l;
  endfunction

endpackage

// File: rtl/optload_pair.sv
module optload_pair
  import optload_pkg::*;
(
  input  byte_t val_i,
  input  byte_t cmp_i,
  output byte_t val_o,
  output logic  bad_o
);

  pair_res_t res;

  always_comb begin
    res   = pair_eval(val_i, cmp_i);
    val_o = res.val;
    bad_o = res.bad;
  end

endmodule

// File: rtl/optload_seq.sv
module optload_seq
  import optload_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              launch_ok_i,
  output logic              start_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cap_v_o,
  output logic [IDX_W-1:0]  cap_idx_o,
  output logic              commit_o,
  output logic              busy_o,
  output logic              done_o
);

  logic             running_q;
  logic             por_pend_q;
  logic [CNT_W-1:0] iss_cnt_q;
  logic             cap_v_q;
  logic [IDX_W-1:0] cap_idx_q;
  logic             done_q;

  assign start_o   = !running_q && (por_pend_q || launch_ok_i);
  assign rd_o      = running_q && (iss_cnt_q < CNT_W'(NUM_WORDS));
  assign addr_o    = ADDR_W'(BASE_ADDR) + ADDR_W'({iss_cnt_q, 2'b00});
  assign cap_v_o   = cap_v_q;
  assign cap_idx_o = cap_idx_q;
  assign commit_o  = cap_v_q && (cap_idx_q == IDX_W'(NUM_WORDS - 1));
  assign busy_o    = running_q;
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      running_q  <= 1'b0;
      por_pend_q <= 1'b1;
      iss_cnt_q  <= '0;
      cap_v_q    <= 1'b0;
      cap_idx_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q  <= commit_o;
      cap_v_q <= rd_o;
      if (rd_o) begin
        cap_idx_q <= iss_cnt_q[IDX_W-1:0];
        iss_cnt_q <= iss_cnt_q + CNT_W'(1);
      end
      if (start_o) begin
        running_q  <= 1'b1;
        por_pend_q <= 1'b0;
        iss_cnt_q  <= '0;
      end else if (commit_o) begin
        running_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/optload_regs.sv
module optload_regs
  import optload_pkg::*;
#(
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              start_i,
  input  logic              cap_v_i,
  input  logic [IDX_W-1:0]  cap_idx_i,
  input  logic              commit_i,
  input  logic              err_clr_i,
  input  byte_t             lo_val_i,
  input  byte_t             hi_val_i,
  input  logic              lo_bad_i,
  input  logic              hi_bad_i,
  output logic [WORD_W-1:0] obr_o,
  output logic [WORD_W-1:0] wrpr_o
);

  byte_t stage_q [NUM_WORDS][PAIRS];
  byte_t nxt     [NUM_WORDS][PAIRS];
  logic  acc_q;
  logic  acc_nxt;
  logic  err_q;

  logic [3*BYTE_W-1:0] obr_data_q;
  rdp_lvl_t            lvl_q;
  logic [WORD_W-1:0]   wrpr_q;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      for (int h = 0; h < PAIRS; h++) begin
        nxt[w][h] = stage_q[w][h];
      end
    end
    if (cap_v_i) begin
      nxt[cap_idx_i][0] = lo_val_i;
      nxt[cap_idx_i][1] = hi_val_i;
    end
    acc_nxt = acc_q || (cap_v_i && (lo_bad_i || hi_bad_i));
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        for (int h = 0; h < PAIRS; h++) begin
          stage_q[w][h] <= '0;
        end
      end
      acc_q <= 1'b0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        for (int h = 0; h < PAIRS; h++) begin
          stage_q[w][h] <= nxt[w][h];
        end
      end
      acc_q <= start_i ? 1'b0 : acc_nxt;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      obr_data_q <= '0;
      lvl_q      <= LVL_OPEN;
      wrpr_q     <= '0;
    end else if (commit_i) begin
      obr_data_q <= {nxt[1][1], nxt[1][0], nxt[0][1]};
      lvl_q      <= rdp_level(nxt[0][0]);
      wrpr_q     <= {nxt[3][1], nxt[3][0], nxt[2][1], nxt[2][0]};
    end
  end

  // Setting on a faulty commit outranks a software clear.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    err_q <= 1'b0;
    else if (start_i)              err_q <= 1'b0;
    else if (commit_i && acc_nxt)  err_q <= 1'b1;
    else if (err_clr_i)            err_q <= 1'b0;
  end

  assign obr_o  = {obr_data_q, 5'b00000, lvl_q, err_q};
  assign wrpr_o = wrpr_q;

endmodule

// File: rtl/optload_top.sv
module optload_top
  import optload_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              launch_i,
  input  logic              err_clr_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] obr_o,
  output logic [WORD_W-1:0] wrpr_o
);

  localparam int IDX_W = $clog2(NUM_WORDS);

  logic             launch_ok;
  logic             clr_ok;
  logic             start_w;
  logic             commit_w;
  logic             cap_v_w;
  logic [IDX_W-1:0] cap_idx_w;
  byte_t            pval [PAIRS];
  logic             pbad [PAIRS];

  assign launch_ok = launch_i && sys_rst_n;
  assign clr_ok    = err_clr_i && sys_rst_n;

  optload_seq #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_seq (
    .clk         (clk),
    .por_n       (por_n),
    .launch_ok_i (launch_ok),
    .start_o     (start_w),
    .rd_o        (mem_rd_o),
    .addr_o      (mem_addr_o),
    .cap_v_o     (cap_v_w),
    .cap_idx_o   (cap_idx_w),
    .commit_o    (commit_w),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    optload_pair u_pair (
      .val_i (mem_rdata_i[p*2*BYTE_W +: BYTE_W]),
      .cmp_i (mem_rdata_i[p*2*BYTE_W+BYTE_W +: BYTE_W]),
      .val_o (pval[p]),
      .bad_o (pbad[p])
    );
  end

  optload_regs u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .start_i   (start_w),
    .cap_v_i   (cap_v_w),
    .cap_idx_i (cap_idx_w),
    .commit_i  (commit_w),
    .err_clr_i (clr_ok),
    .lo_val_i  (pval[0]),
    .hi_val_i  (pval[1]),
    .lo_bad_i  (pbad[0]),
    .hi_bad_i  (pbad[1]),
    .obr_o     (obr_o),
    .wrpr_o    (wrpr_o)
  );

endmodule

// File: rtl/optload_chk.sv
module optload_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done,
  input logic              start,
  input logic              commit,
  input logic [31:0]       obr,
  input logic [31:0]       wrpr
);

  // R1
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd |-> busy);

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd && $past(rd) |-> addr == $past(addr) + ADDR_W'(4));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    done |=> !done);

  // R9
  commit_done_chk: assert property (@(posedge clk) disable iff (!por_n)
    commit |=> done && !busy);

  // R9
  wrpr_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy && $past(busy) |-> $stable(wrpr) && $stable(obr[31:1]));

  // R10
  start_clears_err_chk: assert property (@(posedge clk) disable iff (!por_n)
    start |=> !obr[0]);

endmodule

bind optload_top optload_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .por_n  (por_n),
  .rd     (mem_rd_o),
  .addr   (mem_addr_o),
  .busy   (busy_o),
  .done   (done_o),
  .start  (start_w),
  .commit (commit_w),
  .obr    (obr_o),
  .wrpr   (wrpr_o)
);

// File: tb/sim_optload_top.sv
`timescale 1ns/1ps
module sim_optload_top;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic        launch = 1'b0;
  logic        clr = 1'b0;
  logic        rd;
  logic [7:0]  addr;
  logic [31:0] rdata = '0;
  logic        busy, done;
  logic [31:0] obr, wrpr;

  logic [31:0] mem [4];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // reference model state
  int          m_phase = 0;
  bit          m_pend  = 1'b1;
  logic [31:0] m_obr   = '0;
  logic [31:0] m_wrpr  = '0;
  bit          m_done  = 1'b0;

  always #4 clk = ~clk;

  optload_top u0 (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .launch_i    (launch),
    .err_clr_i   (clr),
    .mem_rd_o    (rd),
    .mem_addr_o  (addr),
    .mem_rdata_i (rdata),
    .busy_o      (busy),
    .done_o      (done),
    .obr_o       (obr),
    .wrpr_o      (wrpr)
  );

  always @(posedge clk) if (rd) rdata <= mem[addr[3:2]];

  function automatic logic [8:0] ref_pair(input logic [7:0] v, input logic [7:0] c);
    if (v == ~c) return {1'b0, v};
    if (v == 8'hFF && c == 8'hFF) return {1'b0, 8'hFF};
    return {1'b1, 8'hFF};
  endfunction

  function automatic logic [1:0] ref_lvl(input logic [7:0] v);
    case (v)
      8'hAA:   return 2'd0;
      8'hCC:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  task automatic model_commit();
    logic [7:0] b [4][2];
    bit any = 0;
    for (int w = 0; w < 4; w++) begin
      logic [8:0] lo, hi;
      lo = ref_pair(mem[w][7:0], mem[w][15:8]);
      hi = ref_pair(mem[w][23:16], mem[w][31:24]);
      b[w][0] = lo[7:0];
      b[w][1] = hi[7:0];
      if (lo[8] || hi[8]) any = 1;
    end
    m_obr  = {b[1][1], b[1][0], b[0][1], 5'd0, ref_lvl(b[0][0]), any};
    m_wrpr = {b[3][1], b[3][0], b[2][1], b[2][0]};
  endtask

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_phase = 0; m_pend = 1; m_obr = '0; m_wrpr = '0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_phase == 5) begin
        model_commit();
        m_phase = 0;
        m_done  = 1;
      end else if (m_phase > 0) begin
        m_phase++;
      end else if (m_pend || (launch && sys_rst_n)) begin
        m_phase  = 1;
        m_pend   = 0;
        m_obr[0] = 1'b0;
      end else if (clr && sys_rst_n) begin
        m_obr[0] = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (por_n) begin
      chk("R1", "busy", {31'd0, busy}, {31'd0, m_phase != 0});
      chk("R1", "rd", {31'd0, rd}, {31'd0, m_phase >= 1 && m_phase <= 4});
      if (rd) chk("R1", "addr", {24'd0, addr}, 32'((m_phase - 1) * 4));
      chk("R9", "done", {31'd0, done}, {31'd0, m_done});
      chk("R6", "obr", obr, m_obr);
      chk("R7", "wrpr", wrpr, m_wrpr);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      summary();
    end
  end

  task automatic pulse_launch();
    @(negedge clk) launch = 1'b1;
    @(negedge clk) launch = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(tag, "done seen", {31'd0, seen}, 32'd1);
  endtask

  initial begin
    mem[0] = {8'hA5, 8'h5A, 8'h55, 8'hAA};
    mem[1] = {8'hED, 8'h12, 8'hCB, 8'h34};
    mem[2] = {8'h0F, 8'hF0, 8'hFE, 8'h01};
    mem[3] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    chk("R1", "reset busy", {31'd0, busy}, 32'd0);
    chk("R1", "reset obr", obr, 32'd0);
    chk("R1", "reset wrpr", wrpr, 32'd0);
    por_n = 1'b1;

    // R1 automatic load after power-on
    @(negedge clk);
    chk("R1", "auto start", {31'd0, busy}, 32'd1);
    wait_done("R1");
    chk("R3", "good pairs obr", obr, 32'h1234_5A00);
    chk("R7", "wrpr map", wrpr, 32'hFFFF_F001);
    chk("R5", "erased word3 no err", {wrpr[31:16], 15'd0, obr[0]}, 32'hFFFF_0000);

    // R4 corrupt low pair of word 1
    mem[1] = {8'hED, 8'h12, 8'h00, 8'h34};
    pulse_launch();
    wait_done("R4");
    chk("R4", "bad byte forced", obr, 32'h12FF_5A01);

    // R10 software clear while idle
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R10", "clear", {31'd0, obr[0]}, 32'd0);

    // R8 levels
    mem[1] = {8'hED, 8'h12, 8'hCB, 8'h34};
    mem[0] = {8'hA5, 8'h5A, 8'h33, 8'hCC};
    pulse_launch();
    wait_done("R8");
    chk("R8", "level full", obr, 32'h1234_5A04);
    mem[0] = {8'hA5, 8'h5A, 8'hEE, 8'h11};
    pulse_launch();
    // R9 registers hold mid-load
    @(negedge clk);
    chk("R9", "hold mid load", obr, 32'h1234_5A04);
    wait_done("R8");
    chk("R8", "level partial", obr, 32'h1234_5A02);

    // R2 launch during load ignored: busy window stays five cycles
    begin
      int nb = 0;
      @(negedge clk) launch = 1'b1;
      @(negedge clk) launch = 1'b0;
      @(negedge clk) launch = 1'b1;
      @(negedge clk) launch = 1'b0;
      nb = 3;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (busy) nb++;
      end
      chk("R2", "busy length", nb, 32'd5);
    end

    // R2 system reset masks launch
    @(negedge clk) begin sys_rst_n = 1'b0; launch = 1'b1; end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "no start in sys reset", {31'd0, busy}, 32'd0);
    end
    launch = 1'b0;
    @(negedge clk) sys_rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "no start after sys reset", {31'd0, busy}, 32'd0);

    // R2 launch while idle
    pulse_launch();
    chk("R2", "launch starts", {31'd0, busy}, 32'd1);
    wait_done("R2");

    // R10 clear in the commit cycle of a faulty load: set wins
    mem[0] = {8'hA5, 8'h5A, 8'h00, 8'hAA};
    pulse_launch();
    for (int i = 0; i < 20 && m_phase != 5; i++) @(negedge clk);
    clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R10", "set wins", {31'd0, obr[0]}, 32'd1);
    chk("R4", "bad rdp level", obr, 32'h1234_5A03);

    // R1 second power-on reload
    mem[0] = {8'hA5, 8'h5A, 8'h55, 8'hAA};
    @(negedge clk) por_n = 1'b0;
    @(negedge clk);
    chk("R1", "por clears obr", obr, 32'd0);
    por_n = 1'b1;
    wait_done("R1");
    chk("R1", "reload after por", obr, 32'h1234_5A00);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule